// File: doc/BRIEF.md
# Control-structure pointer command unit

This unit executes the two pointer-management commands of a hardware virtualization extension. One command retires a control-structure region: it requests that the region's launch state be written back as "clear". If the region is the one currently selected, it also drops the selection. The other command selects a new control structure. It reads a 32-bit revision word from the region over a simple memory read port and compares it with a programmable expected revision. On a match it makes the operand address the current pointer.

Each command passes through an ordered series of checks. Processor-state faults are checked first, then the address itself, then (for a select) the revision word. The outcome is reported as a result code together with a one-cycle done pulse. The current pointer is kept inside the unit, and a dropped pointer always reads as all ones.

Top module: `vptr_cmd_unit`

## Requirements
- R1: Result UD (code 1) is reported when the LOCK flag is set, when the operand is a register, when the extension is not active, in virtual-8086 mode, or when long mode is active with the code-segment long bit clear. UD takes priority over every other outcome.
- R2: When no R1 condition holds and the processor is in guest (non-root) operation, the result is EXIT (code 2).
- R3: When no R1 or R2 condition holds and the privilege level is nonzero, the result is GP (code 3).
- R4: A fault-free command whose operand address has any of bits 11:0 set gets BADADDR (code 4).
- R5: With wide addressing enabled, any operand bit at an index greater than or equal to pa_width gives BADADDR (code 4). With it disabled, any set bit in 63:32 gives BADADDR.
- R6: A valid address equal to root_ptr gives ROOTPTR (code 5). An address that is both invalid and equal to root_ptr gives BADADDR.
- R7: A clear (op 0) that passes all checks gives OK (code 0) and pulses lclr_we with lclr_addr equal to the operand. If the operand equals cur_ptr, cur_ptr becomes all ones and cur_valid drops; otherwise both are unchanged.
- R8: A load (op 1) that passes R1 to R6 raises rd_req with rd_addr equal to the operand, and holds both steady until rd_ack. If rd_data differs from expect_rev, the result is BADREV (code 6) and cur_ptr and cur_valid are unchanged.
- R9: A load whose revision word matches writes the operand into cur_ptr, sets cur_valid and reports OK.
- R10: done is high for exactly one cycle. It follows the accepting edge for commands without a read, and the rd_ack edge for loads. result holds its value until the next done.
- R11: cmd_valid is ignored while busy is high: no done, no lclr_we, and no change to rd_addr.
- R12: After reset, cur_ptr is all ones, cur_valid is 0, done, rd_req and lclr_we are 0, and result is OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 1 | 0 = clear region, 1 = load pointer |
| cmd_lock | input | 1 | LOCK prefix present |
| op_is_reg | input | 1 | Operand encoded as a register |
| virt_on | input | 1 | Virtualization extension active |
| guest_mode | input | 1 | Non-root (guest) operation |
| v86_mode | input | 1 | Virtual-8086 mode |
| long_active | input | 1 | Long mode active |
| cs_long | input | 1 | Code-segment long bit |
| cpl | input | 2 | Current privilege level |
| opnd_addr | input | 64 | Operand physical address |
| root_ptr | input | 64 | Root region pointer of the extension |
| pa_width | input | 7 | Physical address width in bits |
| wide_en | input | 1 | 64-bit addressing supported |
| expect_rev | input | 32 | Expected revision identifier |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 64 | Memory read address |
| rd_ack | input | 1 | Memory read acknowledge, data valid |
| rd_data | input | 32 | Memory read data |
| busy | output | 1 | Read in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Outcome code |
| cur_ptr | output | 64 | Current structure pointer |
| cur_valid | output | 1 | Current pointer valid |
| lclr_we | output | 1 | Launch-state-clear write strobe |
| lclr_addr | output | 64 | Region address for the clear write |

## Verification
The hardest case to reach is a command arriving while a select is waiting on its revision read. The bench stalls rd_ack for several cycles and presents a clear aimed at the live current pointer during the stall. It then checks that neither done nor the clear strobe appears, and that the read address does not move. Priority is exercised by stacking every lower-ranked fault under a higher one and removing the higher conditions one at a time. Invalid addresses are made equal to the root pointer to prove that the address check outranks the root-pointer check.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_UD      = 3'd1,
    RES_EXIT    = 3'd2,
    RES_GP      = 3'd3,
    RES_BADADDR = 3'd4,
    RES_ROOTPTR = 3'd5,
    RES_BADREV  = 3'd6
  } res_e;

  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_LOAD  = 1'b1
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } st_e;
endpackage

// File: rtl/vpc_gate.sv
module vpc_gate
  import vpc_pkg::*;
(
  input  logic       cmd_lock,
  input  logic       op_is_reg,
  input  logic       virt_on,
  input  logic       guest_mode,
  input  logic       v86_mode,
  input  logic       long_active,
  input  logic       cs_long,
  input  logic [1:0] cpl,
  output logic       fault,
  output res_e       fault_code
);
  logic ud_hit;
  logic compat;

  assign compat = long_active && !cs_long;
  assign ud_hit = cmd_lock || op_is_reg || !virt_on || v86_mode || compat;

  always_comb begin
    fault      = 1'b1;
    fault_code = RES_OK;
    if (ud_hit)               fault_code = RES_UD;
    else if (guest_mode)      fault_code = RES_EXIT;
    else if (cpl != 2'd0)     fault_code = RES_GP;
    else                      fault      = 1'b0;
  end

  always_comb begin
    if (!fault) assert_no_fault_at_ring0_R3: assert (cpl == 2'd0 && !guest_mode);
  end
endmodule

// File: rtl/vpc_addr_chk.sv
module vpc_addr_chk #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int NARROW_W  = 32,
  localparam int PAW_W    = $clog2(ADDR_W) + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] root_ptr,
  input  logic [PAW_W-1:0]  pa_width,
  input  logic              wide_en,
  output logic              bad_addr,
  output logic              hits_root
);
  logic [ADDR_W-1:0] over_width;
  logic              misaligned;
  logic              too_wide;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_width
      assign over_width[gi] = addr[gi] && (PAW_W'(gi) >= pa_width);
    end
  endgenerate

  assign misaligned = |addr[PAGE_BITS-1:0];
  assign too_wide   = wide_en ? |over_width : |addr[ADDR_W-1:NARROW_W];
  assign bad_addr   = misaligned || too_wide;
  assign hits_root  = (addr == root_ptr);

  always_comb begin
    if (!bad_addr) assert_aligned_when_ok_R4: assert (addr[PAGE_BITS-1:0] == '0);
  end
endmodule

// File: rtl/vpc_seq.sv
module vpc_seq
  import vpc_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] opnd_addr,
  input  logic              fault,
  input  res_e              fault_code,
  input  logic              bad_addr,
  input  logic              hits_root,
  input  logic [REV_W-1:0]  expect_rev,
  input  logic              rd_ack,
  input  logic [REV_W-1:0]  rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  output res_e              result,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              cur_valid,
  output logic              lclr_we,
  output logic [ADDR_W-1:0] lclr_addr
);
  st_e               st_q, st_d;
  logic              req_q, req_d;
  logic              done_q, done_d;
  res_e              res_q, res_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              vld_q, vld_d;
  logic              lclr_q, lclr_d;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              res_en;
  logic              ptr_en;

  assign accept = cmd_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    req_d  = req_q;
    done_d = 1'b0;
    res_d  = res_q;
    ptr_d  = ptr_q;
    vld_d  = vld_q;
    lclr_d = 1'b0;
    if (accept) begin
      done_d = 1'b1;
      if (fault) begin
        res_d = fault_code;
      end else if (bad_addr) begin
        res_d = RES_BADADDR;
      end else if (hits_root) begin
        res_d = RES_ROOTPTR;
      end else if (cmd_op == OP_CLEAR) begin
        res_d  = RES_OK;
        lclr_d = 1'b1;
        if (opnd_addr == ptr_q) begin
          ptr_d = '1;
          vld_d = 1'b0;
        end
      end else begin
        done_d = 1'b0;
        st_d   = ST_READ;
        req_d  = 1'b1;
      end
    end else if (st_q == ST_READ && rd_ack) begin
      st_d   = ST_IDLE;
      req_d  = 1'b0;
      done_d = 1'b1;
      if (rd_data == expect_rev) begin
        res_d = RES_OK;
        ptr_d = addr_q;
        vld_d = 1'b1;
      end else begin
        res_d = RES_BADREV;
      end
    end
  end

  assign res_en = done_d;
  assign ptr_en = done_d && (res_d == RES_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      lclr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= req_d;
      done_q <= done_d;
      lclr_q <= lclr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_OK;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '1;
      vld_q <= 1'b0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= opnd_addr;
    end
  end

  assign rd_req    = req_q;
  assign rd_addr   = addr_q;
  assign busy      = (st_q == ST_READ);
  assign done      = done_q;
  assign result    = res_q;
  assign cur_ptr   = ptr_q;
  assign cur_valid = vld_q;
  assign lclr_we   = lclr_q;
  assign lclr_addr = addr_q;

  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  assert_invalid_is_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_valid |-> cur_ptr == '1);

  assert_clear_write_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lclr_we |-> done && result == RES_OK);

  assert_ptr_moves_on_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ptr != $past(cur_ptr) |-> done && result == RES_OK);

  assert_no_done_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done && !lclr_we);

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: rtl/vptr_cmd_unit.sv
module vptr_cmd_unit
  import vpc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int REV_W     = 32,
  parameter int PAGE_BITS = 12,
  parameter int NARROW_W  = 32,
  localparam int PAW_W    = $clog2(ADDR_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic              cmd_lock,
  input  logic              op_is_reg,
  input  logic              virt_on,
  input  logic              guest_mode,
  input  logic              v86_mode,
  input  logic              long_active,
  input  logic              cs_long,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] opnd_addr,
  input  logic [ADDR_W-1:0] root_ptr,
  input  logic [PAW_W-1:0]  pa_width,
  input  logic              wide_en,
  input  logic [REV_W-1:0]  expect_rev,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [REV_W-1:0]  rd_data,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              cur_valid,
  output logic              lclr_we,
  output logic [ADDR_W-1:0] lclr_addr
);
  logic fault;
  res_e fault_code;
  logic bad_addr;
  logic hits_root;
  res_e res_w;

  vpc_gate i_gate (
    .cmd_lock    (cmd_lock),
    .op_is_reg   (op_is_reg),
    .virt_on     (virt_on),
    .guest_mode  (guest_mode),
    .v86_mode    (v86_mode),
    .long_active (long_active),
    .cs_long     (cs_long),
    .cpl         (cpl),
    .fault       (fault),
    .fault_code  (fault_code)
  );

  vpc_addr_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .NARROW_W  (NARROW_W)
  ) i_addr_chk (
    .addr      (opnd_addr),
    .root_ptr  (root_ptr),
    .pa_width  (pa_width),
    .wide_en   (wide_en),
    .bad_addr  (bad_addr),
    .hits_root (hits_root)
  );

  vpc_seq #(
    .ADDR_W (ADDR_W),
    .REV_W  (REV_W)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .opnd_addr  (opnd_addr),
    .fault      (fault),
    .fault_code (fault_code),
    .bad_addr   (bad_addr),
    .hits_root  (hits_root),
    .expect_rev (expect_rev),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .done       (done),
    .result     (res_w),
    .cur_ptr    (cur_ptr),
    .cur_valid  (cur_valid),
    .lclr_we    (lclr_we),
    .lclr_addr  (lclr_addr)
  );

  assign result = res_w;
endmodule

// File: tb/test_vptr_cmd_unit.sv
module test_vptr_cmd_unit;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [31:0] REV  = 32'h0001_2345;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_op = 1'b0, cmd_lock = 1'b0, op_is_reg = 1'b0;
  logic        virt_on = 1'b1, guest_mode = 1'b0, v86_mode = 1'b0;
  logic        long_active = 1'b1, cs_long = 1'b1;
  logic [1:0]  cpl = 2'd0;
  logic [63:0] opnd_addr = '0, root_ptr = 64'h1000;
  logic [6:0]  pa_width = 7'd46;
  logic        wide_en = 1'b1;
  logic [31:0] expect_rev = REV;
  logic        rd_req, rd_ack = 1'b0;
  logic [63:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic        busy, done, cur_valid, lclr_we;
  logic [2:0]  result;
  logic [63:0] cur_ptr, lclr_addr;

  int nchecks = 0;
  int nerrs = 0;

  always #2.5 clk = ~clk;

  vptr_cmd_unit i_vptr_cmd_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_lock(cmd_lock), .op_is_reg(op_is_reg), .virt_on(virt_on),
    .guest_mode(guest_mode), .v86_mode(v86_mode), .long_active(long_active),
    .cs_long(cs_long), .cpl(cpl), .opnd_addr(opnd_addr), .root_ptr(root_ptr),
    .pa_width(pa_width), .wide_en(wide_en), .expect_rev(expect_rev),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .result(result), .cur_ptr(cur_ptr),
    .cur_valid(cur_valid), .lclr_we(lclr_we), .lclr_addr(lclr_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic op, input logic [63:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; opnd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [2:0] code);
    chk(req, {63'd0, done}, 64'd1);
    chk(req, {61'd0, result}, {61'd0, code});
  endtask

  task automatic ack(input logic [31:0] d);
    rd_ack = 1'b1; rd_data = d;
    @(negedge clk);
    rd_ack = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 ptr", cur_ptr, ONES);
    chk("R12 valid", {63'd0, cur_valid}, 64'd0);
    chk("R12 done", {63'd0, done}, 64'd0);
    chk("R12 req", {63'd0, rd_req}, 64'd0);
    chk("R12 lclr", {63'd0, lclr_we}, 64'd0);
    chk("R12 result", {61'd0, result}, 64'd0);
  endtask

  task automatic t_priority;
    cmd_lock = 1'b1; guest_mode = 1'b1; cpl = 2'd3;
    issue(1'b0, 64'h2001);
    expect_res("R1 lock over all", 3'd1);
    cmd_lock = 1'b0;
    issue(1'b1, 64'h2001);
    expect_res("R2 exit over gp", 3'd2);
    chk("R8 no read on fault", {63'd0, rd_req}, 64'd0);
    guest_mode = 1'b0;
    issue(1'b0, 64'h2001);
    expect_res("R3 gp over addr", 3'd3);
    cpl = 2'd0;
    op_is_reg = 1'b1; issue(1'b0, 64'h2000); expect_res("R1 reg operand", 3'd1); op_is_reg = 1'b0;
    virt_on = 1'b0; issue(1'b0, 64'h2000); expect_res("R1 not active", 3'd1); virt_on = 1'b1;
    v86_mode = 1'b1; guest_mode = 1'b1; issue(1'b0, 64'h2000); expect_res("R1 v86", 3'd1);
    v86_mode = 1'b0; guest_mode = 1'b0;
    cs_long = 1'b0; issue(1'b1, 64'h2000); expect_res("R1 compat", 3'd1); cs_long = 1'b1;
  endtask

  task automatic t_address;
    issue(1'b0, 64'h2001); expect_res("R4 misaligned", 3'd4);
    chk("R4 no clear", {63'd0, lclr_we}, 64'd0);
    issue(1'b0, 64'h2800); expect_res("R4 bit11", 3'd4);
    issue(1'b0, 64'h0000_4000_0000_0000); expect_res("R5 bit46", 3'd4);
    issue(1'b0, 64'h0000_2000_0000_0000); expect_res("R5 bit45 ok", 3'd0);
    wide_en = 1'b0;
    issue(1'b0, 64'h0000_0001_0000_0000); expect_res("R5 narrow bit32", 3'd4);
    issue(1'b0, 64'h8000_0000); expect_res("R5 narrow bit31 ok", 3'd0);
    wide_en = 1'b1;
    issue(1'b1, 64'h1000); expect_res("R6 root ptr", 3'd5);
    chk("R6 no read", {63'd0, rd_req}, 64'd0);
    root_ptr = 64'h1001;
    issue(1'b0, 64'h1001); expect_res("R6 addr check first", 3'd4);
    root_ptr = 64'h1000;
  endtask

  task automatic t_load;
    issue(1'b1, 64'h5000);
    chk("R8 req", {63'd0, rd_req}, 64'd1);
    chk("R8 addr", rd_addr, 64'h5000);
    chk("R10 no done yet", {63'd0, done}, 64'd0);
    @(negedge clk);
    chk("R8 held", {63'd0, rd_req}, 64'd1);
    ack(32'hBAD);
    expect_res("R8 bad rev", 3'd6);
    chk("R8 req dropped", {63'd0, rd_req}, 64'd0);
    chk("R8 ptr kept", cur_ptr, ONES);
    chk("R8 valid kept", {63'd0, cur_valid}, 64'd0);
    issue(1'b1, 64'h5000);
    ack(REV);
    expect_res("R9 load ok", 3'd0);
    chk("R9 ptr", cur_ptr, 64'h5000);
    chk("R9 valid", {63'd0, cur_valid}, 64'd1);
    @(negedge clk);
    chk("R10 single pulse", {63'd0, done}, 64'd0);
    chk("R10 result held", {61'd0, result}, 64'd0);
  endtask

  task automatic t_clear;
    issue(1'b0, 64'h6000);
    expect_res("R7 clear other", 3'd0);
    chk("R7 we", {63'd0, lclr_we}, 64'd1);
    chk("R7 addr", lclr_addr, 64'h6000);
    chk("R7 ptr kept", cur_ptr, 64'h5000);
    @(negedge clk);
    chk("R7 we pulse", {63'd0, lclr_we}, 64'd0);
    issue(1'b0, 64'h5000);
    expect_res("R7 clear current", 3'd0);
    chk("R7 ptr ones", cur_ptr, ONES);
    chk("R7 invalid", {63'd0, cur_valid}, 64'd0);
  endtask

  task automatic t_busy;
    issue(1'b1, 64'h5000); ack(REV);
    chk("R9 reload", cur_ptr, 64'h5000);
    issue(1'b1, 64'h7000);
    cmd_valid = 1'b1; cmd_op = 1'b0; opnd_addr = 64'h5000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 no done", {63'd0, done}, 64'd0);
      chk("R11 no clear", {63'd0, lclr_we}, 64'd0);
      chk("R11 addr kept", rd_addr, 64'h7000);
      chk("R11 ptr kept", cur_ptr, 64'h5000);
    end
    cmd_valid = 1'b0;
    ack(REV);
    expect_res("R11 load completes", 3'd0);
    chk("R11 ptr new", cur_ptr, 64'h7000);
    chk("R11 valid", {63'd0, cur_valid}, 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_priority;
    t_address;
    t_load;
    t_clear;
    t_busy;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule